// File: doc/BRIEF.md
# UART FIFO Trigger Level and Automatic Flow Control

This block sits next to the 64-entry transmit and receive FIFOs of a UART. It works out the interrupt trigger level for each direction and raises the matching interrupt requests. Each level comes from one of two settings. A non-zero fine setting counts in steps of four characters and takes precedence over a coarse four-way select. While the FIFOs are switched off, both levels fall back to a single character.

The block also handles hardware handshaking, with a separate enable for each side. On the receive side it drives an active-low RTS line from the receive fill count. RTS goes inactive at a halt threshold and becomes active again at a lower resume threshold, and it holds its value between the two. On the transmit side it samples the active-low CTS pin through a two-flop synchronizer. It grants the transmitter's request to start a character only while CTS is active. A character already being shifted out is never cut short, because only the start request is gated.

Top module: `uart_flow_ctl`

## Requirements
- R1: While rst_n is low, rx_irq and tx_irq are 0, rts_n is 1, and with auto CTS enabled tx_permit is 0.
- R2: With fifo_en at 0, the RX and TX trigger levels are both 1 character, whatever the select and fine fields hold.
- R3: With fifo_en at 1, the RX level is 4 times rx_prog when rx_prog is non-zero. Otherwise rx_sel values 0, 1, 2 and 3 select 8, 16, 56 and 60.
- R4: With fifo_en at 1, the TX level is 4 times tx_prog when tx_prog is non-zero. Otherwise tx_sel values 0, 1, 2 and 3 select 8, 16, 32 and 56.
- R5: One cycle after a clock edge, rx_irq equals (rx_fill >= RX level) as sampled at that edge.
- R6: One cycle after a clock edge, tx_irq equals ((64 - tx_fill) >= TX level) as sampled at that edge.
- R7: With auto RTS disabled (flow_en bit 0 = 0), rts_n is 0 after the next clock edge.
- R8: With auto RTS enabled, at each edge rts_n becomes 1 if rx_fill >= halt. Otherwise it becomes 0 if rx_fill <= resume, and otherwise it keeps its value. Halt is 4*halt_lvl and resume is 4*resume_lvl, and halt wins when both conditions hold.
- R9: When halt_lvl and resume_lvl are both 0, halt is the coarse RX level (rx_sel, or 1 if fifo_en is 0) and resume is that level minus 8 (or 0 if fifo_en is 0).
- R10: With auto CTS enabled (flow_en bit 1 = 1), tx_permit equals tx_req while the synchronized CTS is active. A change on cts_n reaches tx_permit after the second clock edge.
- R11: The two flow_en bits act independently: bit 1 alone gates only tx_permit, and bit 0 alone drives only rts_n. With bit 1 at 0, tx_permit follows tx_req in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| rx_sel | input | 2 | Coarse RX trigger select |
| tx_sel | input | 2 | Coarse TX trigger select |
| rx_prog | input | 4 | Fine RX trigger, units of 4 |
| tx_prog | input | 4 | Fine TX trigger, units of 4 |
| halt_lvl | input | 4 | RTS halt threshold, units of 4 |
| resume_lvl | input | 4 | RTS resume threshold, units of 4 |
| flow_en | input | 2 | Bit 1 auto CTS, bit 0 auto RTS |
| rx_fill | input | 7 | Receive FIFO fill count |
| tx_fill | input | 7 | Transmit FIFO fill count |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_req | input | 1 | Transmitter requests to start a character |
| tx_permit | output | 1 | Start of character granted |
| rx_irq | output | 1 | Receive trigger reached |
| tx_irq | output | 1 | Transmit space trigger reached |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The hard case is the RTS hold band. There, the output depends on the direction from which the fill count entered the band, and it depends on how the thresholds interact when they overlap or are inverted. The stimulus ramps the receive fill from empty to full and back down for a set of threshold pairs. These include the zero-field fallback, equal thresholds and a resume threshold above the halt threshold. The bench compares each step against a hysteresis model of its own. Both interrupt levels are swept exhaustively over every select, fine value and fill count, with the FIFOs on and off.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int PROG_W     = 4;
  localparam int PROG_UNIT  = 4;
  localparam int RESUME_GAP = 8;

  function automatic logic [CNT_W-1:0] rx_coarse_lvl(input logic [1:0] sel);
    logic [CNT_W-1:0] v;
    case (sel)
      2'd0:    v = CNT_W'(8);
      2'd1:    v = CNT_W'(16);
      2'd2:    v = CNT_W'(56);
      default: v = CNT_W'(60);
    endcase
    return v;
  endfunction

  function automatic logic [CNT_W-1:0] tx_coarse_lvl(input logic [1:0] sel);
    logic [CNT_W-1:0] v;
    case (sel)
      2'd0:    v = CNT_W'(8);
      2'd1:    v = CNT_W'(16);
      2'd2:    v = CNT_W'(32);
      default: v = CNT_W'(56);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/trig_level_sel.sv
module trig_level_sel
  import uart_flow_pkg::*;
#(
  parameter bit IS_RX = 1'b1,
  parameter int CW    = CNT_W,
  parameter int PW    = PROG_W,
  parameter int UNIT  = PROG_UNIT
) (
  input  logic          fifo_en,
  input  logic [1:0]    sel,
  input  logic [PW-1:0] prog,
  output logic [CW-1:0] lvl
);
  logic [CW-1:0] coarse;
  logic [CW-1:0] fine;

  generate
    if (IS_RX) begin : g_rx
      assign coarse = rx_coarse_lvl(sel);
    end else begin : g_tx
      assign coarse = tx_coarse_lvl(sel);
    end
  endgenerate

  assign fine = CW'(prog) * CW'(UNIT);

  always_comb begin
    if (!fifo_en)
      lvl = CW'(1);
    else if (prog != '0)
      lvl = fine;
    else
      lvl = coarse;
  end
endmodule

// File: rtl/irq_compare.sv
module irq_compare #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] amount,
  input  logic [CW-1:0] lvl,
  output logic          irq
);
  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = (amount >= lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else
      irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/rts_hyst.sv
module rts_hyst #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] fill,
  input  logic [CW-1:0] halt_thr,
  input  logic [CW-1:0] resume_thr,
  output logic          rts_n
);
  logic rts_n_d;
  logic rts_n_q;

  always_comb begin
    rts_n_d = rts_n_q;
    if (!en)
      rts_n_d = 1'b0;
    else if (fill >= halt_thr)
      rts_n_d = 1'b1;
    else if (fill <= resume_thr)
      rts_n_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rts_n_q <= 1'b1;
    else
      rts_n_q <= rts_n_d;
  end

  assign rts_n = rts_n_q;
endmodule

// File: rtl/cts_gate.sv
module cts_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cts_n,
  input  logic tx_req,
  output logic tx_permit
);
  logic [SYNC_STAGES-1:0] sync_d;
  logic [SYNC_STAGES-1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], cts_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sync_q <= '1;
    else
      sync_q <= sync_d;
  end

  assign tx_permit = tx_req & (~en | ~sync_q[SYNC_STAGES-1]);
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import uart_flow_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH,
  parameter int CW    = CNT_W,
  parameter int PW    = PROG_W,
  parameter int UNIT  = PROG_UNIT,
  parameter int GAP   = RESUME_GAP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    rx_sel,
  input  logic [1:0]    tx_sel,
  input  logic [PW-1:0] rx_prog,
  input  logic [PW-1:0] tx_prog,
  input  logic [PW-1:0] halt_lvl,
  input  logic [PW-1:0] resume_lvl,
  input  logic [1:0]    flow_en,
  input  logic [CW-1:0] rx_fill,
  input  logic [CW-1:0] tx_fill,
  input  logic          cts_n,
  input  logic          tx_req,
  output logic          tx_permit,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          rts_n
);
  localparam logic [CW-1:0] DEPTH_W = CW'(DEPTH);
  localparam logic [CW-1:0] UNIT_W  = CW'(UNIT);
  localparam logic [CW-1:0] GAP_W   = CW'(GAP);

  logic [CW-1:0] rx_lvl;
  logic [CW-1:0] tx_lvl;
  logic [CW-1:0] tx_free;
  logic [CW-1:0] halt_thr;
  logic [CW-1:0] resume_thr;
  logic [CW-1:0] fb_halt;
  logic [CW-1:0] fb_resume;

  trig_level_sel #(.IS_RX(1'b1), .CW(CW), .PW(PW), .UNIT(UNIT)) u_rx_lvl (
    .fifo_en (fifo_en),
    .sel     (rx_sel),
    .prog    (rx_prog),
    .lvl     (rx_lvl)
  );

  trig_level_sel #(.IS_RX(1'b0), .CW(CW), .PW(PW), .UNIT(UNIT)) u_tx_lvl (
    .fifo_en (fifo_en),
    .sel     (tx_sel),
    .prog    (tx_prog),
    .lvl     (tx_lvl)
  );

  assign tx_free = DEPTH_W - tx_fill;

  irq_compare #(.CW(CW)) u_rx_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .amount (rx_fill),
    .lvl    (rx_lvl),
    .irq    (rx_irq)
  );

  irq_compare #(.CW(CW)) u_tx_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .amount (tx_free),
    .lvl    (tx_lvl),
    .irq    (tx_irq)
  );

  // Threshold fallback: with both threshold fields clear, follow the coarse RX select.
  always_comb begin
    if (fifo_en) begin
      fb_halt   = rx_coarse_lvl(rx_sel);
      fb_resume = rx_coarse_lvl(rx_sel) - GAP_W;
    end else begin
      fb_halt   = CW'(1);
      fb_resume = '0;
    end
    if ((halt_lvl == '0) && (resume_lvl == '0)) begin
      halt_thr   = fb_halt;
      resume_thr = fb_resume;
    end else begin
      halt_thr   = CW'(halt_lvl) * UNIT_W;
      resume_thr = CW'(resume_lvl) * UNIT_W;
    end
  end

  rts_hyst #(.CW(CW)) u_rts (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (flow_en[0]),
    .fill       (rx_fill),
    .halt_thr   (halt_thr),
    .resume_thr (resume_thr),
    .rts_n      (rts_n)
  );

  cts_gate #(.SYNC_STAGES(2)) u_cts (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (flow_en[1]),
    .cts_n     (cts_n),
    .tx_req    (tx_req),
    .tx_permit (tx_permit)
  );
endmodule

// File: rtl/uart_flow_chk.sv
module uart_flow_chk #(
  parameter int CW    = 7,
  parameter int DEPTH = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    flow_en,
  input logic [CW-1:0] rx_fill,
  input logic [CW-1:0] tx_fill,
  input logic          cts_n,
  input logic          tx_req,
  input logic          tx_permit,
  input logic          rx_irq,
  input logic          tx_irq,
  input logic          rts_n
);
  a_r7_rts_off: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en[0] |=> !rts_n);

  a_r8_full_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en[0] && rx_fill >= CW'(DEPTH)) |=> rts_n);

  a_r5_full_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill >= CW'(DEPTH)) |=> rx_irq);

  a_r6_empty_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fill == '0) |=> tx_irq);

  a_r10_permit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    tx_permit |-> tx_req);

  a_r10_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en[1] && $past(cts_n) && $past(cts_n, 2) && $stable(flow_en)) |-> !tx_permit);
endmodule

bind uart_flow_ctl uart_flow_chk #(.CW(CW), .DEPTH(DEPTH)) u_flow_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flow_en   (flow_en),
  .rx_fill   (rx_fill),
  .tx_fill   (tx_fill),
  .cts_n     (cts_n),
  .tx_req    (tx_req),
  .tx_permit (tx_permit),
  .rx_irq    (rx_irq),
  .tx_irq    (tx_irq),
  .rts_n     (rts_n)
);

// File: tb/uart_flow_ctl_bench.sv
`timescale 1ns/1ps
module uart_flow_ctl_bench;
  logic       clk;
  logic       rst_n;
  logic       fifo_en;
  logic [1:0] rx_sel, tx_sel;
  logic [3:0] rx_prog, tx_prog, halt_lvl, resume_lvl;
  logic [1:0] flow_en;
  logic [6:0] rx_fill, tx_fill;
  logic       cts_n, tx_req;
  logic       tx_permit, rx_irq, tx_irq, rts_n;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  uart_flow_ctl u_uart_flow_ctl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_sel(rx_sel), .tx_sel(tx_sel),
    .rx_prog(rx_prog), .tx_prog(tx_prog), .halt_lvl(halt_lvl), .resume_lvl(resume_lvl),
    .flow_en(flow_en), .rx_fill(rx_fill), .tx_fill(tx_fill), .cts_n(cts_n),
    .tx_req(tx_req), .tx_permit(tx_permit), .rx_irq(rx_irq), .tx_irq(tx_irq),
    .rts_n(rts_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rx_lvl(input int fe, input int sel, input int prog);
    int c[4] = '{8, 16, 56, 60};
    if (fe == 0) return 1;
    if (prog != 0) return 4 * prog;
    return c[sel];
  endfunction

  function automatic int tx_lvl(input int fe, input int sel, input int prog);
    int c[4] = '{8, 16, 32, 56};
    if (fe == 0) return 1;
    if (prog != 0) return 4 * prog;
    return c[sel];
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic rts_sweep(input int fe, input int sel, input int h, input int r);
    int hth, rth, exp;
    string tag;
    if (h == 0 && r == 0) begin
      hth = (fe != 0) ? rx_lvl(1, sel, 0) : 1;
      rth = (fe != 0) ? hth - 8 : 0;
      tag = "R9";
    end else begin
      hth = 4 * h;
      rth = 4 * r;
      tag = "R8";
    end
    exp = 0;
    for (int k = 0; k <= 128; k++) begin
      int f = (k <= 64) ? k : 128 - k;
      @(negedge clk);
      fifo_en = fe[0]; rx_sel = sel[1:0]; halt_lvl = h[3:0]; resume_lvl = r[3:0];
      rx_fill = f[6:0];
      step();
      if (f >= hth) exp = 1;
      else if (f <= rth) exp = 0;
      chk(tag, rts_n, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; rx_sel = '0; tx_sel = '0; rx_prog = '0; tx_prog = '0;
    halt_lvl = '0; resume_lvl = '0; flow_en = 2'b10; rx_fill = '0; tx_fill = '0;
    cts_n = 1'b0; tx_req = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 rts_n", rts_n, 1);
    chk("R1 tx_permit", tx_permit, 0);
    @(negedge clk);
    rst_n = 1'b1;
    flow_en = 2'b00;

    // R2 R3 R5: exhaustive RX trigger sweep
    for (int fe = 0; fe < 2; fe++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 16; p++)
          for (int f = 0; f <= 64; f++) begin
            @(negedge clk);
            fifo_en = fe[0]; rx_sel = s[1:0]; rx_prog = p[3:0]; rx_fill = f[6:0];
            step();
            chk((fe == 0) ? "R2/R5 rx" : ((p != 0) ? "R3 fine/R5" : "R3 coarse/R5"),
                rx_irq, (f >= rx_lvl(fe, s, p)) ? 1 : 0);
          end

    // R2 R4 R6: exhaustive TX trigger sweep
    for (int fe = 0; fe < 2; fe++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 16; p++)
          for (int f = 0; f <= 64; f++) begin
            @(negedge clk);
            fifo_en = fe[0]; tx_sel = s[1:0]; tx_prog = p[3:0]; tx_fill = f[6:0];
            step();
            chk((fe == 0) ? "R2/R6 tx" : ((p != 0) ? "R4 fine/R6" : "R4 coarse/R6"),
                tx_irq, ((64 - f) >= tx_lvl(fe, s, p)) ? 1 : 0);
          end

    // R7: RTS released when auto RTS off, even with a full FIFO
    @(negedge clk);
    flow_en = 2'b00; rx_fill = 7'd64;
    step();
    chk("R7", rts_n, 0);

    // R8 R9: hysteresis sweeps
    flow_en = 2'b01;
    for (int s = 0; s < 4; s++) rts_sweep(1, s, 0, 0);
    rts_sweep(0, 2, 0, 0);
    rts_sweep(1, 0, 12, 4);
    rts_sweep(1, 3, 8, 8);
    rts_sweep(1, 1, 3, 10);
    rts_sweep(1, 0, 0, 5);
    rts_sweep(0, 0, 15, 1);

    // R11: RTS-only keeps CTS out of the permit path
    @(negedge clk);
    flow_en = 2'b01; cts_n = 1'b1; tx_req = 1'b1; rx_fill = 7'd64;
    #1;
    chk("R11 permit", tx_permit, 1);
    step();
    chk("R11 rts", rts_n, 1);
    @(negedge clk);
    tx_req = 1'b0;
    #1;
    chk("R11 no req", tx_permit, 0);

    // R10: CTS synchronizer latency and gating
    @(negedge clk);
    flow_en = 2'b10; cts_n = 1'b1; tx_req = 1'b1;
    step(); step(); step();
    chk("R10 blocked", tx_permit, 0);
    chk("R11 cts only rts", rts_n, 0);
    @(negedge clk);
    cts_n = 1'b0;
    step();
    chk("R10 one edge", tx_permit, 0);
    step();
    chk("R10 two edges", tx_permit, 1);
    @(negedge clk);
    tx_req = 1'b0;
    #1;
    chk("R10 no req", tx_permit, 0);
    @(negedge clk);
    tx_req = 1'b1; cts_n = 1'b1;
    step();
    chk("R10 still open", tx_permit, 1);
    step();
    chk("R10 closed", tx_permit, 0);
    @(negedge clk);
    flow_en = 2'b00;
    #1;
    chk("R11 cts off", tx_permit, 1);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule